// File: doc/BRIEF.md
# PLL Configuration and Lock Sequencer

This block is the register-side controller for one phase-locked loop. It keeps a 32-bit control word with four ratio fields and an enable bit, and one bit of a shared bypass word. It also models the loop's lock behaviour: a counter stands in for the analog settling time. Software writes a new ratio or enables the loop, then polls a read-only stable flag until it rises.

The ratio fields hold each ratio minus one. The two post-dividers multiply, and a post-divider field of 0 is treated as a ratio of 1. The block reports the ratio the loop would produce as a multiplier and a total divider. When the loop is off or bypassed, it reports that the output follows the reference clock instead. The lock time is a count of reference cycles, given on an input port.

A parameter picks which of three loops this instance serves. That choice fixes the bit position of its bypass flag in the shared word: bit 30, 28 or 26.

Top module: `pll_cfg_ctrl`

## Requirements
- R1: After reset the control read-back is 0, the bypass read-back is 0, stable is low, the output follows the reference, and the reported multiplier and divider are both 1.
- R2: Control word layout: bit 0 is enable, bits 31:20 hold M-1, bits 19:14 hold N-1, bits 13:11 hold post-divider B and bits 10:8 hold post-divider A. These fields read back as written. Bits 7:4 and 2:1 always read 0.
- R3: When enabled and not bypassed, the reported multiplier is M and the divider is N x A' x B'. Here A' and B' equal their field value, except that a field value of 0 counts as 1.
- R4: When disabled or bypassed, follows_ref is 1 and both the multiplier and the divider read 1.
- R5: A write that turns enable from 0 to 1 leaves stable low after that write edge. Stable rises exactly L clock edges later, where L is lock_cycles, with 0 treated as 1.
- R6: A write with enable 0 forces stable low at that edge, and it stays low until a later enabling write.
- R7: A write that keeps enable at 1 and changes any ratio field, while not bypassed, drops stable at that edge. Stable rises again L edges later. A further change during the wait restarts the count.
- R8: An enabled write that leaves every ratio field unchanged does not disturb stable. The same holds for a ratio change while bypassed.
- R9: Bit 3 of the control word reads the stable flag, and writes to bit 3 are ignored.
- R10: In the bypass word, only bit 30 - 2*PLL_SEL is stored (bit 28 by default). Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| byp_wr | input | 1 | Write strobe for the shared bypass word |
| byp_wdata | input | 32 | Bypass word write data |
| lock_cycles | input | LOCK_W | Lock time in reference cycles (0 acts as 1) |
| ctrl_rdata | output | 32 | Control word read-back, with stable at bit 3 |
| byp_rdata | output | 32 | Bypass word read-back, only this loop's bit |
| pll_stable | output | 1 | Loop reported locked |
| follows_ref | output | 1 | Output equals the reference clock |
| ratio_mult | output | 13 | Effective multiplier M |
| ratio_div | output | 13 | Effective total divider N x A' x B' |

## Verification
A wrong stored field shows up at the ports within one cycle, in two places: in the read-back, and as a reported ratio that differs from the arithmetic product. The bench sweeps every combination of input divider and post-dividers to expose this. A lock counter that is off by one, or that fails to restart, moves the rising edge of stable away from exactly L edges after the write. The bench therefore samples stable on every edge of the wait for several values of L, including 0. A wrong restart or keep decision shows up as stable staying high after a real ratio change, or dropping after a write that changes nothing.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
    // control word field positions and widths
    localparam int EN_BIT  = 0;
    localparam int STB_BIT = 3;
    localparam int ODA_LSB = 8;
    localparam int ODB_LSB = 11;
    localparam int OD_W    = 3;
    localparam int N_LSB   = 14;
    localparam int N_W     = 6;
    localparam int M_LSB   = 20;
    localparam int M_W     = 12;
    // derived result widths
    localparam int MULT_W  = M_W + 1;
    localparam int DIV_W   = N_W + 1 + 2 * OD_W;

    typedef struct packed {
        logic            en;
        logic [M_W-1:0]  mul;
        logic [N_W-1:0]  ind;
        logic [OD_W-1:0] oda;
        logic [OD_W-1:0] odb;
    } pll_cfg_t;

    typedef struct packed {
        pll_cfg_t cfg;
        logic     byp;
    } pll_state_t;
endpackage

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc
    import pll_cfg_pkg::*;
(
    input  logic              follow,
    input  logic [M_W-1:0]    mul,
    input  logic [N_W-1:0]    ind,
    input  logic [OD_W-1:0]   oda,
    input  logic [OD_W-1:0]   odb,
    output logic [MULT_W-1:0] ratio_mult,
    output logic [DIV_W-1:0]  ratio_div
);
    localparam int NUM_OD = 2;

    logic [OD_W-1:0] od_raw [NUM_OD];
    logic [OD_W-1:0] od_eff [NUM_OD];
    logic [N_W:0]    n_eff;

    assign od_raw[0] = oda;
    assign od_raw[1] = odb;

    // a zero post-divider field behaves as a divide-by-one
    for (genvar g = 0; g < NUM_OD; g++) begin : g_od
        assign od_eff[g] = (od_raw[g] == '0) ? OD_W'(1) : od_raw[g];
    end

    assign n_eff = {1'b0, ind} + (N_W+1)'(1);

    always_comb begin
        if (follow) begin
            ratio_mult = MULT_W'(1);
            ratio_div  = DIV_W'(1);
        end else begin
            ratio_mult = MULT_W'(mul) + MULT_W'(1);
            ratio_div  = DIV_W'(n_eff) * DIV_W'(od_eff[0]) * DIV_W'(od_eff[1]);
        end
    end
endmodule

// File: rtl/pll_lock_seq.sv
module pll_lock_seq #(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              cancel,
    input  logic [LOCK_W-1:0] lock_cycles,
    output logic              stable
);
    typedef struct packed {
        logic              stable;
        logic              busy;
        logic [LOCK_W-1:0] cnt;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic [LOCK_W-1:0] target;
    logic [LOCK_W:0]   cnt_inc;

    always_comb begin
        seq_d   = seq_q;
        target  = (lock_cycles == '0) ? LOCK_W'(1) : lock_cycles;
        cnt_inc = {1'b0, seq_q.cnt} + (LOCK_W+1)'(1);
        if (cancel) begin
            seq_d = '0;
        end else if (restart) begin
            seq_d.stable = 1'b0;
            seq_d.busy   = 1'b1;
            seq_d.cnt    = '0;
        end else if (seq_q.busy) begin
            seq_d.cnt = cnt_inc[LOCK_W-1:0];
            if (cnt_inc >= {1'b0, target}) begin
                seq_d.stable = 1'b1;
                seq_d.busy   = 1'b0;
                seq_d.cnt    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign stable = seq_q.stable;
endmodule

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
    import pll_cfg_pkg::*;
#(
    parameter int PLL_SEL = 1,
    parameter int LOCK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [31:0]       ctrl_wdata,
    input  logic              byp_wr,
    input  logic [31:0]       byp_wdata,
    input  logic [LOCK_W-1:0] lock_cycles,
    output logic [31:0]       ctrl_rdata,
    output logic [31:0]       byp_rdata,
    output logic              pll_stable,
    output logic              follows_ref,
    output logic [MULT_W-1:0] ratio_mult,
    output logic [DIV_W-1:0]  ratio_div
);
    localparam int BYP_BIT = 30 - 2 * PLL_SEL;

    pll_state_t st_d, st_q;
    pll_cfg_t   wr_cfg;
    logic       params_diff;
    logic       restart;
    logic       cancel;

    always_comb begin
        wr_cfg.en  = ctrl_wdata[EN_BIT];
        wr_cfg.mul = ctrl_wdata[M_LSB +: M_W];
        wr_cfg.ind = ctrl_wdata[N_LSB +: N_W];
        wr_cfg.oda = ctrl_wdata[ODA_LSB +: OD_W];
        wr_cfg.odb = ctrl_wdata[ODB_LSB +: OD_W];

        params_diff = (wr_cfg.mul != st_q.cfg.mul) || (wr_cfg.ind != st_q.cfg.ind) ||
                      (wr_cfg.oda != st_q.cfg.oda) || (wr_cfg.odb != st_q.cfg.odb);

        restart = ctrl_wr && wr_cfg.en && (!st_q.cfg.en || (params_diff && !st_q.byp));
        cancel  = ctrl_wr && !wr_cfg.en;

        st_d = st_q;
        if (ctrl_wr) st_d.cfg = wr_cfg;
        if (byp_wr)  st_d.byp = byp_wdata[BYP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pll_lock_seq #(.LOCK_W(LOCK_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .cancel     (cancel),
        .lock_cycles(lock_cycles),
        .stable     (pll_stable)
    );

    assign follows_ref = !st_q.cfg.en || st_q.byp;

    pll_ratio_calc u_ratio (
        .follow    (follows_ref),
        .mul       (st_q.cfg.mul),
        .ind       (st_q.cfg.ind),
        .oda       (st_q.cfg.oda),
        .odb       (st_q.cfg.odb),
        .ratio_mult(ratio_mult),
        .ratio_div (ratio_div)
    );

    always_comb begin
        ctrl_rdata                     = '0;
        ctrl_rdata[EN_BIT]             = st_q.cfg.en;
        ctrl_rdata[STB_BIT]            = pll_stable;
        ctrl_rdata[M_LSB +: M_W]       = st_q.cfg.mul;
        ctrl_rdata[N_LSB +: N_W]       = st_q.cfg.ind;
        ctrl_rdata[ODA_LSB +: OD_W]    = st_q.cfg.oda;
        ctrl_rdata[ODB_LSB +: OD_W]    = st_q.cfg.odb;
        byp_rdata                      = '0;
        byp_rdata[BYP_BIT]             = st_q.byp;
    end
endmodule

// File: rtl/pll_cfg_ctrl_chk.sv
module pll_cfg_ctrl_chk
    import pll_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [31:0]       ctrl_wdata,
    input logic [31:0]       ctrl_rdata,
    input logic [31:0]       byp_rdata,
    input logic              pll_stable,
    input logic              follows_ref,
    input logic [MULT_W-1:0] ratio_mult,
    input logic [DIV_W-1:0]  ratio_div
);
    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !ctrl_wdata[0] |=> !pll_stable);

    p_stable_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pll_stable |-> ctrl_rdata[0]);

    p_ref_ratio_r4: assert property (@(posedge clk) disable iff (!rst_n)
        follows_ref |-> (ratio_mult == MULT_W'(1)) && (ratio_div == DIV_W'(1)));

    p_relock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_wdata[0] && ctrl_rdata[0] && (byp_rdata == '0) &&
        (ctrl_wdata[31:8] != ctrl_rdata[31:8]) |=> !pll_stable);

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_stable && ctrl_wr && ctrl_wdata[0] &&
        (ctrl_wdata[31:8] == ctrl_rdata[31:8]) |=> pll_stable);

    p_byp_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(byp_rdata) <= 1);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[7:4] == 4'h0) && (ctrl_rdata[2:1] == 2'b00));
endmodule

bind pll_cfg_ctrl pll_cfg_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .byp_rdata  (byp_rdata),
    .pll_stable (pll_stable),
    .follows_ref(follows_ref),
    .ratio_mult (ratio_mult),
    .ratio_div  (ratio_div)
);

// File: tb/pll_cfg_ctrl_bench.sv
module pll_cfg_ctrl_bench;
    localparam int LOCK_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_wr = 1'b0;
    logic [31:0]       ctrl_wdata = '0;
    logic              byp_wr = 1'b0;
    logic [31:0]       byp_wdata = '0;
    logic [LOCK_W-1:0] lock_cycles = 8'd1;
    logic [31:0]       ctrl_rdata;
    logic [31:0]       byp_rdata;
    logic              pll_stable;
    logic              follows_ref;
    logic [12:0]       ratio_mult;
    logic [12:0]       ratio_div;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pll_cfg_ctrl #(.PLL_SEL(1), .LOCK_W(LOCK_W)) u_pll_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .byp_wr(byp_wr), .byp_wdata(byp_wdata), .lock_cycles(lock_cycles),
        .ctrl_rdata(ctrl_rdata), .byp_rdata(byp_rdata), .pll_stable(pll_stable),
        .follows_ref(follows_ref), .ratio_mult(ratio_mult), .ratio_div(ratio_div)
    );

    function automatic logic [31:0] mk(input logic en, input int m, input int n,
                                       input int oda, input int odb);
        return {m[11:0], n[5:0], odb[2:0], oda[2:0], 7'b0, en};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(posedge clk); @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_byp(input logic [31:0] d);
        byp_wr = 1'b1; byp_wdata = d;
        @(posedge clk); @(negedge clk);
        byp_wr = 1'b0;
    endtask

    // called right after the restarting write; stable must rise exactly at edge leff
    task automatic expect_lock(input int leff, input string req);
        check(pll_stable == 1'b0, req, 32'(pll_stable), 0);
        for (int k = 1; k <= leff; k++) begin
            @(posedge clk); @(negedge clk);
            check(pll_stable == (k == leff), req, 32'(pll_stable), 32'(k == leff));
        end
    endtask

    task automatic hold_low(input int cyc, input string req);
        for (int k = 0; k < cyc; k++) begin
            @(posedge clk); @(negedge clk);
            check(pll_stable == 1'b0, req, 32'(pll_stable), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int lset [5] = '{0, 1, 2, 5, 17};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(ctrl_rdata == 0, "R1 ctrl", ctrl_rdata, 0);
        check(byp_rdata == 0, "R1 byp", byp_rdata, 0);
        check(pll_stable == 0, "R1 stable", 32'(pll_stable), 0);
        check(follows_ref == 1, "R1 follows", 32'(follows_ref), 1);
        check(ratio_mult == 1 && ratio_div == 1, "R1 ratio",
              {3'b0, ratio_mult, 3'b0, ratio_div}, 32'h0001_0001);

        // R2 / R9 layout: all ones written, bit 3 write ignored (stable low after start)
        lock_cycles = 8'd3;
        wr_ctrl(32'hFFFF_FFFF);
        check(ctrl_rdata == 32'hFFFF_FF01, "R2 readback", ctrl_rdata, 32'hFFFF_FF01);
        check(ctrl_rdata[3] == 1'b0, "R9 bit3 write ignored", 32'(ctrl_rdata[3]), 0);
        wr_ctrl(mk(1'b0, 0, 0, 0, 0));

        // R5 enable lock timing, L=0 behaves as 1
        foreach (lset[i]) begin
            lock_cycles = 8'(lset[i]);
            wr_ctrl(mk(1'b1, 100 + i, 3, 2, 5));
            expect_lock((lset[i] == 0) ? 1 : lset[i], "R5 enable lock");
            hold_low(0, "R5");
            wr_ctrl(mk(1'b0, 100 + i, 3, 2, 5));
            check(pll_stable == 0, "R6 disable after lock", 32'(pll_stable), 0);
        end

        // R7 relock after ratio change
        lock_cycles = 8'd4;
        wr_ctrl(mk(1'b1, 40, 1, 1, 1));
        expect_lock(4, "R5 enable");
        wr_ctrl(mk(1'b1, 41, 1, 1, 1));
        expect_lock(4, "R7 relock M");
        wr_ctrl(mk(1'b1, 41, 1, 3, 1));
        expect_lock(4, "R7 relock OD");
        // R7 restart during wait
        lock_cycles = 8'd6;
        wr_ctrl(mk(1'b1, 41, 2, 3, 1));
        repeat (3) @(negedge clk);
        check(pll_stable == 0, "R7 mid wait", 32'(pll_stable), 0);
        wr_ctrl(mk(1'b1, 41, 2, 3, 2));
        expect_lock(6, "R7 restart count");

        // R8 same params keep stable, R9 bit 3 written 0 reads stable
        wr_ctrl(mk(1'b1, 41, 2, 3, 2));
        check(pll_stable == 1, "R8 same params", 32'(pll_stable), 1);
        check(ctrl_rdata[3] == 1, "R9 bit3 shows stable", 32'(ctrl_rdata[3]), 1);
        wr_ctrl(mk(1'b1, 41, 2, 3, 2) | 32'h8);
        repeat (4) @(negedge clk);
        check(pll_stable == 1, "R8 repeat write", 32'(pll_stable), 1);

        // R6 disable while locked, and during wait
        wr_ctrl(mk(1'b0, 41, 2, 3, 2));
        hold_low(10, "R6 disabled stays low");
        lock_cycles = 8'd10;
        wr_ctrl(mk(1'b1, 41, 2, 3, 2));
        repeat (3) @(negedge clk);
        wr_ctrl(mk(1'b0, 41, 2, 3, 2));
        hold_low(15, "R6 cancel during wait");

        // R10 bypass bit position (bit 28 for this instance)
        wr_byp(32'hFFFF_FFFF);
        check(byp_rdata == 32'h1000_0000, "R10 own bit", byp_rdata, 32'h1000_0000);
        wr_byp(32'h4400_0000);
        check(byp_rdata == 0, "R10 other bits", byp_rdata, 0);

        // R8 / R4 ratio change while bypassed
        lock_cycles = 8'd2;
        wr_ctrl(mk(1'b1, 7, 0, 0, 0));
        expect_lock(2, "R5 enable");
        wr_byp(32'h1000_0000);
        check(follows_ref == 1 && ratio_mult == 1 && ratio_div == 1, "R4 bypass ratio",
              {3'b0, ratio_mult, 3'b0, ratio_div}, 32'h0001_0001);
        wr_ctrl(mk(1'b1, 9, 4, 2, 2));
        repeat (3) @(negedge clk);
        check(pll_stable == 1, "R8 bypassed change", 32'(pll_stable), 1);
        wr_byp(32'h0);
        check(follows_ref == 0 && ratio_mult == 10 && ratio_div == 20, "R3 unbypassed",
              {3'b0, ratio_mult, 3'b0, ratio_div}, 32'h000A_0014);

        // R3 / R4 sweep over N and both post-dividers
        lock_cycles = 8'd1;
        for (int n = 0; n < 64; n++) begin
            for (int a = 0; a < 8; a++) begin
                for (int b = 0; b < 8; b++) begin
                    int m;
                    int ediv;
                    m = (n * 97 + a * 13 + b * 511) % 4096;
                    ediv = (n + 1) * ((a == 0) ? 1 : a) * ((b == 0) ? 1 : b);
                    wr_ctrl(mk(1'b1, m, n, a, b));
                    check(follows_ref == 0 && ratio_mult == 13'(m + 1) && ratio_div == 13'(ediv),
                          "R3 ratio", {3'b0, ratio_mult, 3'b0, ratio_div},
                          {16'(m + 1), 16'(ediv)});
                    check(ctrl_rdata[31:8] == mk(1'b1, m, n, a, b) >> 8, "R2 fields",
                          ctrl_rdata, mk(1'b1, m, n, a, b));
                    if (b == 7) begin
                        wr_ctrl(mk(1'b0, m, n, a, b));
                        check(follows_ref == 1 && ratio_mult == 1 && ratio_div == 1,
                              "R4 disabled ratio", {3'b0, ratio_mult, 3'b0, ratio_div},
                              32'h0001_0001);
                    end
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule